// File: doc/BRIEF.md
# Bank Extension and Monitor Address Mapper

This block turns a 14-bit virtual address into a 16-bit physical address for accesses that do not go through the per-user relocation table. It serves two mapping schemes. In normal mode, two 3-bit bank registers stand in for the top two address bits whenever an access falls in the upper half of the 16K window. Monitor mode uses the same rule for the 8K to 12K range. In monitor mode the top 4K is instead split into two 2K pages. Each page takes its physical block from its own 5-bit page register.

A start pulse returns both bank registers to the values that make the normal-mode map an identity. A set command writes both bank registers in one cycle. The monitor page registers are loaded in two steps: a clear command first, then a data word from which two 5-bit fields are taken. A page register that holds zero marks its page as out of bounds, and any access to that page raises a trap. Two indicator outputs show when a bank register has moved away from its identity value. The address path is combinational from the registered state, so a lookup costs no cycle.

Top module: `bank_monitor_mapper`

## Requirements
- R1: In either mode, a virtual address with bit 13 equal to 0 (range 0 to 8K-1) appears unchanged on `paddr_o`, with bits 15:14 at zero.
- R2: A virtual address with bits 13:12 equal to binary 10 gives `paddr_o = {1'b0, bank_lo, vaddr[11:0]}` in both modes. `bank_lo` is the bank register for this range.
- R3: In normal mode (`mode_i` = 0), a virtual address with bits 13:12 equal to binary 11 gives `paddr_o = {1'b0, bank_hi, vaddr[11:0]}`. `bank_hi` is the second bank register.
- R4: Reset and `start_i` both load `bank_lo` with 2 and `bank_hi` with 3, which makes R2/R3 an identity. When `start_i` and `ext_set_i` are high in the same cycle, `start_i` wins.
- R5: In monitor mode (`mode_i` = 1), a virtual address with bits 13:12 equal to binary 11 gives `paddr_o = {page, vaddr[10:0]}`. `page` is the low page register when `vaddr[11]` is 0 and the high page register when it is 1. `bank_hi` has no effect in this case.
- R6: `trap_o` is 1 exactly when R5 applies and the selected page register holds zero. Both page registers reset to zero.
- R7: `mon_clr_i` zeroes both page registers and arms a load. The next `mon_load_i` then takes `mon_data_i[10:6]` into the low page register and `mon_data_i[4:0]` into the high page register, and ignores every other bit of the word. A load while not armed changes nothing. Clear beats load in the same cycle, and a load disarms.
- R8: `ext_set_i` writes `ext_data_i[5:3]` to `bank_lo` and `ext_data_i[2:0]` to `bank_hi`. Both registers are written in the same cycle.
- R9: `bank_lo_alt_o` is 1 exactly when `bank_lo` is not 2, and `bank_hi_alt_o` is 1 exactly when `bank_hi` is not 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 1 | 0 = normal mode, 1 = monitor mode |
| vaddr_i | input | 14 | Virtual address |
| start_i | input | 1 | Return bank registers to identity values |
| ext_set_i | input | 1 | Write both bank registers |
| ext_data_i | input | 6 | Bank values: [5:3] low range, [2:0] high range |
| mon_clr_i | input | 1 | Clear page registers and arm a load |
| mon_load_i | input | 1 | Load page registers from data word when armed |
| mon_data_i | input | 24 | Page data word |
| paddr_o | output | 16 | Physical address |
| trap_o | output | 1 | Out-of-bounds monitor page access |
| bank_lo_alt_o | output | 1 | Low bank register differs from 2 |
| bank_hi_alt_o | output | 1 | High bank register differs from 3 |

## Verification
Two pairs of commands can fall in the same cycle. The first pair is a start pulse and a bank set. The second pair is a page clear and a page load. The bench raises both commands of each pair on one clock edge. It then judges the result only through the address path. The bank case must show identity mapping and dropped indicators. The page case must show zeroed pages that trap, followed by a later load that is still accepted. A load with no clear before it is checked against the unchanged translated addresses.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;

  typedef enum logic {
    MAP_NORMAL  = 1'b0,
    MAP_MONITOR = 1'b1
  } map_mode_e;

  typedef enum logic [1:0] {
    REG_DIRECT  = 2'd0,
    REG_BANK_LO = 2'd1,
    REG_BANK_HI = 2'd2,
    REG_PAGE    = 2'd3
  } map_region_e;

endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_n_sync = shift_q[STAGES-1];

endmodule

// File: rtl/bank_ext_regs.sv
module bank_ext_regs #(
  parameter int BANK_W  = 3,
  parameter int DEF_LO  = 2,
  parameter int DEF_HI  = 3,
  localparam int DATA_W = 2 * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              set_i,
  input  logic [DATA_W-1:0] set_data_i,
  output logic [BANK_W-1:0] bank_lo_o,
  output logic [BANK_W-1:0] bank_hi_o
);

  localparam logic [BANK_W-1:0] RST_LO = BANK_W'(DEF_LO);
  localparam logic [BANK_W-1:0] RST_HI = BANK_W'(DEF_HI);

  logic [BANK_W-1:0] lo_q, lo_d;
  logic [BANK_W-1:0] hi_q, hi_d;
  logic              wr_en;

  assign wr_en = start_i | set_i;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (start_i) begin
      lo_d = RST_LO;
      hi_d = RST_HI;
    end else if (set_i) begin
      lo_d = set_data_i[DATA_W-1:BANK_W];
      hi_d = set_data_i[BANK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= RST_LO;
      hi_q <= RST_HI;
    end else if (wr_en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign bank_lo_o = lo_q;
  assign bank_hi_o = hi_q;

  AST_START_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (bank_lo_o == RST_LO) && (bank_hi_o == RST_HI)); // R4

  AST_SET_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !start_i) |=> (bank_lo_o == $past(set_data_i[DATA_W-1:BANK_W])) &&
                            (bank_hi_o == $past(set_data_i[BANK_W-1:0]))); // R8

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !start_i) |=> $stable(bank_lo_o) && $stable(bank_hi_o)); // R8

endmodule

// File: rtl/mon_page_regs.sv
module mon_page_regs #(
  parameter int BLK_W   = 5,
  parameter int WORD_W  = 24,
  parameter int LO_LSB  = 6,
  parameter int HI_LSB  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [BLK_W-1:0]  page_lo_o,
  output logic [BLK_W-1:0]  page_hi_o
);

  logic [BLK_W-1:0] lo_q, lo_d;
  logic [BLK_W-1:0] hi_q, hi_d;
  logic             armed_q, armed_d;
  logic             take_load;
  logic             upd_en;

  assign take_load = load_i & armed_q & ~clr_i;
  assign upd_en    = clr_i | load_i;

  always_comb begin
    lo_d    = lo_q;
    hi_d    = hi_q;
    armed_d = armed_q;
    if (clr_i) begin
      lo_d    = '0;
      hi_d    = '0;
      armed_d = 1'b1;
    end else if (take_load) begin
      lo_d    = data_i[LO_LSB +: BLK_W];
      hi_d    = data_i[HI_LSB +: BLK_W];
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      armed_q <= 1'b0;
    end else if (upd_en) begin
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      armed_q <= armed_d;
    end
  end

  assign page_lo_o = lo_q;
  assign page_hi_o = hi_q;

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (page_lo_o == '0) && (page_hi_o == '0)); // R7

  AST_UNARMED_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !armed_q && !clr_i) |=> $stable(page_lo_o) && $stable(page_hi_o)); // R7

  AST_ARMED_LOAD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && armed_q && !clr_i) |=> (page_lo_o == $past(data_i[LO_LSB +: BLK_W])) &&
                                      (page_hi_o == $past(data_i[HI_LSB +: BLK_W]))); // R7

endmodule

// File: rtl/addr_translate.sv
module addr_translate
  import addr_map_pkg::*;
#(
  parameter int VA_W   = 14,
  parameter int PA_W   = 16,
  parameter int BANK_W = 3,
  parameter int BLK_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [BANK_W-1:0] bank_lo_i,
  input  logic [BANK_W-1:0] bank_hi_i,
  input  logic [BLK_W-1:0]  page_lo_i,
  input  logic [BLK_W-1:0]  page_hi_i,
  output logic [PA_W-1:0]   paddr_o,
  output logic              trap_o
);

  localparam int BANK_OFF_W = VA_W - 2;
  localparam int PAGE_OFF_W = VA_W - 3;

  map_mode_e         mode;
  map_region_e       region;
  logic [1:0]        top_bits;
  logic [BLK_W-1:0]  page_sel;

  assign mode     = map_mode_e'(mode_i);
  assign top_bits = vaddr_i[VA_W-1:VA_W-2];
  assign page_sel = vaddr_i[PAGE_OFF_W] ? page_hi_i : page_lo_i;

  always_comb begin
    unique case (top_bits)
      2'b10:   region = REG_BANK_LO;
      2'b11:   region = (mode == MAP_MONITOR) ? REG_PAGE : REG_BANK_HI;
      default: region = REG_DIRECT;
    endcase
  end

  always_comb begin
    trap_o = 1'b0;
    unique case (region)
      REG_BANK_LO: paddr_o = PA_W'({bank_lo_i, vaddr_i[BANK_OFF_W-1:0]});
      REG_BANK_HI: paddr_o = PA_W'({bank_hi_i, vaddr_i[BANK_OFF_W-1:0]});
      REG_PAGE: begin
        paddr_o = PA_W'({page_sel, vaddr_i[PAGE_OFF_W-1:0]});
        trap_o  = (page_sel == '0);
      end
      default:     paddr_o = PA_W'(vaddr_i);
    endcase
  end

  AST_LOW_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !vaddr_i[VA_W-1] |-> (paddr_o == PA_W'(vaddr_i))); // R1

  AST_TRAP_ONLY_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (mode_i && (vaddr_i[VA_W-1:VA_W-2] == 2'b11))); // R6

  AST_BANK_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (vaddr_i[VA_W-1] && !(mode_i && vaddr_i[VA_W-2])) |-> !paddr_o[PA_W-1]); // R2

  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && vaddr_i[VA_W-1] && vaddr_i[VA_W-2]) |->
      (paddr_o[PAGE_OFF_W-1:0] == vaddr_i[PAGE_OFF_W-1:0])); // R5

endmodule

// File: rtl/bank_monitor_mapper.sv
module bank_monitor_mapper #(
  parameter int VA_W    = 14,
  parameter int PA_W    = 16,
  parameter int BANK_W  = 3,
  parameter int BLK_W   = 5,
  parameter int WORD_W  = 24,
  parameter int DEF_LO  = 2,
  parameter int DEF_HI  = 3,
  localparam int EXT_W  = 2 * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic              start_i,
  input  logic              ext_set_i,
  input  logic [EXT_W-1:0]  ext_data_i,
  input  logic              mon_clr_i,
  input  logic              mon_load_i,
  input  logic [WORD_W-1:0] mon_data_i,
  output logic [PA_W-1:0]   paddr_o,
  output logic              trap_o,
  output logic              bank_lo_alt_o,
  output logic              bank_hi_alt_o
);

  logic              rst_n_s;
  logic [BANK_W-1:0] bank_lo, bank_hi;
  logic [BLK_W-1:0]  page_lo, page_hi;

  rst_release_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  bank_ext_regs #(
    .BANK_W (BANK_W),
    .DEF_LO (DEF_LO),
    .DEF_HI (DEF_HI)
  ) u_banks (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_i),
    .set_i      (ext_set_i),
    .set_data_i (ext_data_i),
    .bank_lo_o  (bank_lo),
    .bank_hi_o  (bank_hi)
  );

  mon_page_regs #(
    .BLK_W  (BLK_W),
    .WORD_W (WORD_W),
    .LO_LSB (6),
    .HI_LSB (0)
  ) u_pages (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr_i     (mon_clr_i),
    .load_i    (mon_load_i),
    .data_i    (mon_data_i),
    .page_lo_o (page_lo),
    .page_hi_o (page_hi)
  );

  addr_translate #(
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .BANK_W (BANK_W),
    .BLK_W  (BLK_W)
  ) u_xlate (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .mode_i    (mode_i),
    .vaddr_i   (vaddr_i),
    .bank_lo_i (bank_lo),
    .bank_hi_i (bank_hi),
    .page_lo_i (page_lo),
    .page_hi_i (page_hi),
    .paddr_o   (paddr_o),
    .trap_o    (trap_o)
  );

  assign bank_lo_alt_o = (bank_lo != BANK_W'(DEF_LO));
  assign bank_hi_alt_o = (bank_hi != BANK_W'(DEF_HI));

  AST_START_CLEARS_ALT: assert property (@(posedge clk) disable iff (!rst_n_s)
    start_i |=> !bank_lo_alt_o && !bank_hi_alt_o); // R9

  AST_SET_ALT_LO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ext_set_i && !start_i) |=>
      (bank_lo_alt_o == ($past(ext_data_i[EXT_W-1:BANK_W]) != BANK_W'(DEF_LO)))); // R9

endmodule

// File: tb/bank_monitor_mapper_bench.sv
module bank_monitor_mapper_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_i;
  logic [13:0] vaddr_i;
  logic        start_i, ext_set_i, mon_clr_i, mon_load_i;
  logic [5:0]  ext_data_i;
  logic [23:0] mon_data_i;
  logic [15:0] paddr_o;
  logic        trap_o, bank_lo_alt_o, bank_hi_alt_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bank_monitor_mapper u_bank_monitor_mapper (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .vaddr_i(vaddr_i),
    .start_i(start_i), .ext_set_i(ext_set_i), .ext_data_i(ext_data_i),
    .mon_clr_i(mon_clr_i), .mon_load_i(mon_load_i), .mon_data_i(mon_data_i),
    .paddr_o(paddr_o), .trap_o(trap_o),
    .bank_lo_alt_o(bank_lo_alt_o), .bank_hi_alt_o(bank_hi_alt_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic probe(input string req, input logic md, input logic [13:0] va,
                       input logic [15:0] exp_pa, input logic exp_trap);
    mode_i  = md;
    vaddr_i = va;
    #1;
    chk({req, " paddr"}, 32'(paddr_o), 32'(exp_pa));
    chk({req, " trap"},  32'(trap_o),  32'(exp_trap));
  endtask

  task automatic cmd(input logic st, input logic set, input logic [5:0] ed,
                     input logic clr, input logic ld, input logic [23:0] md);
    @(negedge clk);
    start_i = st; ext_set_i = set; ext_data_i = ed;
    mon_clr_i = clr; mon_load_i = ld; mon_data_i = md;
    @(negedge clk);
    start_i = 0; ext_set_i = 0; mon_clr_i = 0; mon_load_i = 0;
    ext_data_i = '0; mon_data_i = '0;
  endtask

  task automatic t_reset_state();
    probe("R4 reset identity lo", 1'b0, 14'h2ABC, 16'h2ABC, 1'b0);
    probe("R4 reset identity hi", 1'b0, 14'h3DEF, 16'h3DEF, 1'b0);
    chk("R9 reset lo alt", 32'(bank_lo_alt_o), 32'd0);
    chk("R9 reset hi alt", 32'(bank_hi_alt_o), 32'd0);
    probe("R6 reset page traps", 1'b1, 14'h3000, 16'h0000, 1'b1);
  endtask

  task automatic t_low_pass();
    probe("R1 normal low", 1'b0, 14'h1234, 16'h1234, 1'b0);
    probe("R1 monitor low", 1'b1, 14'h1FFF, 16'h1FFF, 1'b0);
  endtask

  task automatic t_bank_set();
    cmd(1'b0, 1'b1, 6'b101_110, 1'b0, 1'b0, '0);
    probe("R2 R8 normal lo bank", 1'b0, 14'h2123, 16'h5123, 1'b0);
    probe("R2 monitor lo bank",   1'b1, 14'h2FFF, 16'h5FFF, 1'b0);
    probe("R3 R8 normal hi bank", 1'b0, 14'h3456, 16'h6456, 1'b0);
    probe("R1 low unaffected by bank", 1'b0, 14'h0456, 16'h0456, 1'b0);
    chk("R9 lo alt after set", 32'(bank_lo_alt_o), 32'd1);
    chk("R9 hi alt after set", 32'(bank_hi_alt_o), 32'd1);
    cmd(1'b0, 1'b1, 6'b010_111, 1'b0, 1'b0, '0);
    chk("R9 lo alt back at 2", 32'(bank_lo_alt_o), 32'd0);
    chk("R9 hi alt at 7", 32'(bank_hi_alt_o), 32'd1);
    probe("R3 hi bank 7", 1'b0, 14'h3001, 16'h7001, 1'b0);
  endtask

  task automatic t_start_vs_set();
    cmd(1'b1, 1'b1, 6'b111_000, 1'b0, 1'b0, '0);
    probe("R4 start wins lo", 1'b0, 14'h2222, 16'h2222, 1'b0);
    probe("R4 start wins hi", 1'b0, 14'h3333, 16'h3333, 1'b0);
    chk("R9 start drops lo alt", 32'(bank_lo_alt_o), 32'd0);
    chk("R9 start drops hi alt", 32'(bank_hi_alt_o), 32'd0);
  endtask

  task automatic t_page_load();
    logic [23:0] word;
    word = 24'hFFF800 | (24'h13 << 6) | 24'h20 | 24'h0A;
    cmd(1'b0, 1'b1, 6'b100_001, 1'b0, 1'b0, '0);
    cmd(1'b0, 1'b0, '0, 1'b1, 1'b0, '0);
    probe("R6 cleared lo traps", 1'b1, 14'h3100, 16'h0100, 1'b1);
    probe("R6 cleared hi traps", 1'b1, 14'h3A05, 16'h0205, 1'b1);
    cmd(1'b0, 1'b0, '0, 1'b0, 1'b1, word);
    probe("R5 R7 page lo field", 1'b1, 14'h3100, 16'h9900, 1'b0);
    probe("R5 R7 page hi field", 1'b1, 14'h3A05, 16'h5205, 1'b0);
    probe("R3 normal ignores pages", 1'b0, 14'h3100, 16'h1100, 1'b0);
    probe("R2 monitor mid range bank", 1'b1, 14'h2010, 16'h4010, 1'b0);
    cmd(1'b0, 1'b0, '0, 1'b0, 1'b1, 24'h0007C1);
    probe("R7 unarmed load ignored lo", 1'b1, 14'h3100, 16'h9900, 1'b0);
    probe("R7 unarmed load ignored hi", 1'b1, 14'h3A05, 16'h5205, 1'b0);
    cmd(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_page_partial();
    cmd(1'b0, 1'b0, '0, 1'b1, 1'b0, '0);
    cmd(1'b0, 1'b0, '0, 1'b0, 1'b1, 24'h000040);
    probe("R5 lo page value 1", 1'b1, 14'h37FF, 16'h0FFF, 1'b0);
    probe("R6 zero hi page traps", 1'b1, 14'h3800, 16'h0000, 1'b1);
  endtask

  task automatic t_clr_vs_load();
    cmd(1'b0, 1'b0, '0, 1'b1, 1'b1, 24'h0007FF);
    probe("R7 clear wins lo", 1'b1, 14'h3010, 16'h0010, 1'b1);
    probe("R7 clear wins hi", 1'b1, 14'h3810, 16'h0010, 1'b1);
    cmd(1'b0, 1'b0, '0, 1'b0, 1'b1, 24'h000FDF);
    probe("R7 armed after collision lo", 1'b1, 14'h3010, 16'hF810, 1'b0);
    probe("R7 armed after collision hi", 1'b1, 14'h3810, 16'hF810, 1'b0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; mode_i = 0; vaddr_i = '0;
    start_i = 0; ext_set_i = 0; ext_data_i = '0;
    mon_clr_i = 0; mon_load_i = 0; mon_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_low_pass();
    t_bank_set();
    t_start_vs_set();
    t_page_load();
    t_page_partial();
    t_clr_vs_load();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule